// File: doc/BRIEF.md
# Host Bus Controller for an 8-bit Converter Pair

This block sits between an 8-bit parallel host bus and the digital side of a converter pair: an analog-to-digital conversion sequencer and an 8-bit output register that feeds a digital-to-analog stage. The host drives active-low strobes for chip select, read, write and start, plus an active-low bus reset. Every strobe and the incoming data byte pass through a synchroniser into the system clock domain. All edge detection and handshaking then happen in that domain.

A conversion can be requested in two ways. In strobe mode, a falling edge on the start strobe begins a conversion whatever the chip select is doing. In read mode, the start strobe is parked high and a read cycle (chip select and read both low) begins a conversion. The host then waits on the busy flag before it takes the new byte. While a conversion runs, the busy output is low. When the conversion finishes, the interrupt output falls. The output latch is what the bus returns during a read, so a read issued mid-conversion sees the previous result. The conversion datapath is a stub: it samples `sample_i` at the start and presents it as the result after a fixed latency.

The bus reset input clears the output register and the interrupt at once, but a conversion that is running carries on to completion. A start strobe that arrives while busy is discarded, and a sticky protocol-error flag records it.

Top module: `hostbus_ctrl`

## Requirements
- R1: After system reset, busy_n and int_n are 1, dac_q is 0, data_oe is 0 and proto_err is 0.
- R2: A falling edge on st_n starts a conversion whatever the state of cs_n. busy_n falls on the third rising clock edge after the strobe edge and stays low for exactly LAT (default 8) clocks.
- R3: With st_n high, the moment cs_n and rd_n are both low starts a conversion. busy_n falls one clock after data_oe rises. With st_n low, a read starts nothing.
- R4: The conversion result equals sample_i as it was in the clock that started the conversion. The bus keeps the previous result until busy_n returns high.
- R5: int_n falls in the same clock in which busy_n returns high. It stays low until a rising edge on either cs_n or rd_n, and returns high on the third rising clock edge after that input edge.
- R6: data_oe is 1 only while the synchronised cs_n and rd_n are both low. It follows them after two clock edges, and data_o carries the result latch while it is 1.
- R7: dac_q loads data_i on a rising edge of wr_n while cs_n is low, and also on a rising edge of cs_n while wr_n is low. The load takes effect on the third clock edge. Holding both low, or a wr_n rise while cs_n is high, leaves dac_q unchanged.
- R8: clr_n low forces int_n high and dac_q and proto_err to 0 without waiting for a clock. dac_q stays 0 until the next valid write, and a running conversion completes with its normal timing and result.
- R9: A start request during a conversion neither restarts it nor changes its result. A falling edge of st_n during a conversion sets proto_err, which holds until clr_n or system reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| clr_n | input | 1 | Bus reset, active low: clears output register, interrupt and error flag |
| cs_n | input | 1 | Chip select strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, loads on rising edge |
| st_n | input | 1 | Start strobe, conversion begins on falling edge |
| data_i | input | DW | Bus byte from the host, bit DW-1 is MSB |
| sample_i | input | DW | Value the conversion stub captures at start |
| data_o | output | DW | Bus byte to the host (result latch) |
| data_oe | output | 1 | Bus drive enable; bus is high impedance when 0 |
| busy_n | output | 1 | Conversion in progress, active low |
| int_n | output | 1 | Conversion complete interrupt, active low |
| proto_err | output | 1 | Sticky flag: start strobe seen while busy |
| dac_q | output | DW | Output register feeding the D/A stage |

## Verification
The bench probes four edges of the rules. First, the exact clock on which busy falls and rises in each start mode. A design that detected edges on unsynchronised strobes, or that counted one stage too few, would move these by a clock. Second, a mid-conversion read must return the stale byte; a design that updated the latch early would return the new sample. Third, a second start strobe inside a conversion must leave the busy window and the result intact; a restarting design would stretch busy and return the second sample. Finally, the bus reset is pulsed during a conversion. A design that tied it to the sequencer would lose the result, and one that cleared the interrupt only at a clock edge, or kept the register after a write with chip select high, is caught at the ports.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  // Strobe positions inside the synchronised strobe vector.
  localparam int NSTRB  = 4;
  localparam int IDX_CS = 0;
  localparam int IDX_RD = 1;
  localparam int IDX_WR = 2;
  localparam int IDX_ST = 3;

  // Which request, if any, wants to start a conversion this clock.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_STROBE = 2'd1,
    SRC_READ   = 2'd2
  } start_src_e;

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int   W       = 1,
  parameter int   DEPTH   = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= {W{RST_VAL}};
        else        stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= {W{RST_VAL}};
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/hbc_conv_stub.sv
module hbc_conv_stub #(
  parameter int DW  = 8,
  parameter int LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] sample,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);

  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] res_q, res_d;
  logic          fin;

  assign fin = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    res_d  = res_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
      hold_d = sample;
    end else if (fin) begin
      busy_d = 1'b0;
      res_d  = hold_q;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      res_q  <= res_d;
    end
  end

  assign busy   = busy_q;
  assign done   = fin;
  assign result = res_q;

endmodule

// File: rtl/hbc_dac_reg.sv
module hbc_dac_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_lvl,
  input  logic          wr_prev,
  input  logic          cs_lvl,
  input  logic          cs_prev,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic          load;
  logic [DW-1:0] q_r, q_d;

  // Load on the closing edge of a write cycle: whichever of the two
  // strobes rises while the other was still low.
  assign load = (wr_lvl && !wr_prev && !cs_prev) ||
                (cs_lvl && !cs_prev && !wr_prev);

  always_comb begin
    q_d = q_r;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q_r <= '0;
    else         q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
  import hbc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int LAT         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          st_n,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] sample_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          busy_n,
  output logic          int_n,
  output logic          proto_err,
  output logic [DW-1:0] dac_q
);

  localparam int RSYNC = 2;

  // ---------------- strobe and data synchronisers ----------------
  logic [NSTRB-1:0] strb_raw, strb_lvl, strb_prev, strb_prev_d;
  logic [DW-1:0]    data_s;

  always_comb begin
    strb_raw         = '1;
    strb_raw[IDX_CS] = cs_n;
    strb_raw[IDX_RD] = rd_n;
    strb_raw[IDX_WR] = wr_n;
    strb_raw[IDX_ST] = st_n;
  end

  hbc_sync #(.W(NSTRB), .DEPTH(SYNC_STAGES), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_lvl)
  );

  hbc_sync #(.W(DW), .DEPTH(SYNC_STAGES), .RST_VAL(1'b0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(data_i), .q(data_s)
  );

  assign strb_prev_d = strb_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_prev <= '1;
    else        strb_prev <= strb_prev_d;
  end

  // ---------------- bus reset: async assert, sync release ----------------
  logic             soft_arst_n;
  logic [RSYNC-1:0] srst_q;
  logic             soft_rst_n;

  assign soft_arst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge soft_arst_n) begin
    if (!soft_arst_n) srst_q <= '0;
    else              srst_q <= {srst_q[RSYNC-2:0], 1'b1};
  end

  assign soft_rst_n = srst_q[RSYNC-1];

  // ---------------- start arbitration ----------------
  logic       st_fall, rdsel_now, rdsel_prev, rd_start;
  logic       conv_busy, conv_done, conv_start;
  start_src_e src_sel;

  assign st_fall    = !strb_lvl[IDX_ST] && strb_prev[IDX_ST];
  assign rdsel_now  = !strb_lvl[IDX_CS] && !strb_lvl[IDX_RD];
  assign rdsel_prev = !strb_prev[IDX_CS] && !strb_prev[IDX_RD];
  assign rd_start   = rdsel_now && !rdsel_prev && strb_lvl[IDX_ST];

  always_comb begin
    src_sel = SRC_NONE;
    if (st_fall)       src_sel = SRC_STROBE;
    else if (rd_start) src_sel = SRC_READ;
  end

  assign conv_start = (src_sel != SRC_NONE) && !conv_busy;

  logic [DW-1:0] conv_res;

  hbc_conv_stub #(.DW(DW), .LAT(LAT)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .sample(sample_i),
    .busy(conv_busy), .done(conv_done), .result(conv_res)
  );

  // ---------------- interrupt and protocol flag ----------------
  logic int_low_q, int_low_d, int_clear;
  logic perr_q, perr_d;

  assign int_clear = (strb_lvl[IDX_CS] && !strb_prev[IDX_CS]) ||
                     (strb_lvl[IDX_RD] && !strb_prev[IDX_RD]);

  always_comb begin
    int_low_d = int_low_q;
    if (conv_done)      int_low_d = 1'b1;
    else if (int_clear) int_low_d = 1'b0;
    perr_d = perr_q;
    if (st_fall && conv_busy) perr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      int_low_q <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      int_low_q <= int_low_d;
      perr_q    <= perr_d;
    end
  end

  // ---------------- output register ----------------
  hbc_dac_reg #(.DW(DW)) u_dac (
    .clk(clk), .arst_n(soft_rst_n),
    .wr_lvl(strb_lvl[IDX_WR]), .wr_prev(strb_prev[IDX_WR]),
    .cs_lvl(strb_lvl[IDX_CS]), .cs_prev(strb_prev[IDX_CS]),
    .d(data_s), .q(dac_q)
  );

  // ---------------- outputs ----------------
  assign data_oe   = rdsel_now;
  assign data_o    = rdsel_now ? conv_res : '0;
  assign busy_n    = !conv_busy;
  assign int_n     = !int_low_q;
  assign proto_err = perr_q;

endmodule

// File: rtl/hbc_chk.sv
module hbc_chk
  import hbc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LAT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             busy_n,
  input logic             int_n,
  input logic             data_oe,
  input logic             proto_err,
  input logic [DW-1:0]    dac_q,
  input logic             soft_rst_n,
  input logic [NSTRB-1:0] strb_lvl,
  input logic [NSTRB-1:0] strb_prev
);

  localparam int BW = $clog2(LAT + 2);

  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          wr_up, cs_up;

  always_comb begin
    bcnt_d = bcnt_q;
    if (busy_n)                    bcnt_d = '0;
    else if (bcnt_q != BW'(LAT+1)) bcnt_d = bcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  assign wr_up = strb_lvl[IDX_WR] && !strb_prev[IDX_WR];
  assign cs_up = strb_lvl[IDX_CS] && !strb_prev[IDX_CS];

  // R2: busy window is exactly LAT clocks long
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> bcnt_q == BW'(LAT));

  // R3: a read cycle with start strobe high begins a conversion
  assert_read_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) && strb_lvl[IDX_ST] && busy_n |=> !busy_n);

  // R5: interrupt falls as the conversion ends
  assert_int_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) && soft_rst_n && $past(soft_rst_n) |-> !int_n);

  // R7: the output register only moves after a closing write edge
  assert_dac_load_R7: assert property (@(posedge clk) disable iff (!soft_rst_n)
    $past(soft_rst_n) && (dac_q != $past(dac_q)) |-> $past(wr_up || cs_up));

  // R8: bus reset clears register, interrupt and flag
  assert_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> int_n && (dac_q == '0) && !proto_err);

  // R9: the protocol flag is raised only inside a conversion
  assert_err_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> !$past(busy_n));

endmodule

bind hostbus_ctrl hbc_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .busy_n(busy_n), .int_n(int_n),
  .data_oe(data_oe), .proto_err(proto_err), .dac_q(dac_q),
  .soft_rst_n(soft_rst_n), .strb_lvl(strb_lvl), .strb_prev(strb_prev)
);

// File: tb/sim_hostbus_ctrl.sv
module sim_hostbus_ctrl;

  logic       clk, rst_n, clr_n, cs_n, rd_n, wr_n, st_n;
  logic [7:0] data_i, sample_i, data_o, dac_q;
  logic       data_oe, busy_n, int_n, proto_err;

  int n_chk  = 0;
  int n_fail = 0;

  hostbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .st_n(st_n), .data_i(data_i), .sample_i(sample_i),
    .data_o(data_o), .data_oe(data_oe), .busy_n(busy_n), .int_n(int_n),
    .proto_err(proto_err), .dac_q(dac_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    st_n = 1'b1; data_i = 8'h00; sample_i = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 busy_n", busy_n, 1);
    chk("R1 int_n", int_n, 1);
    chk("R1 dac_q", dac_q, 0);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 proto_err", proto_err, 0);
  endtask

  // Strobe-mode conversion, then a read with st_n low
  task automatic t_mode1;
    sample_i = 8'hA5;
    cs_n = 1'b0;              // cs low must not matter for the strobe start
    step(1);
    cs_n = 1'b1;
    step(1);
    st_n = 1'b0;
    step(2); chk("R2 busy_n before sync", busy_n, 1);
    step(1); chk("R2 busy_n falls", busy_n, 0);
    sample_i = 8'h00;
    step(7); chk("R2 busy_n still low", busy_n, 0);
    step(1); chk("R2 busy_n ends", busy_n, 1);
    chk("R5 int_n at end", int_n, 0);
    chk("R9 no error", proto_err, 0);
    cs_n = 1'b0; rd_n = 1'b0;
    step(1); chk("R6 oe after one edge", data_oe, 0);
    step(1); chk("R6 oe on", data_oe, 1);
    chk("R4 result", data_o, 8'hA5);
    step(1); chk("R3 no start with st_n low", busy_n, 1);
    rd_n = 1'b1;
    step(2); chk("R5 int_n held", int_n, 0);
    chk("R6 oe off", data_oe, 0);
    step(1); chk("R5 int_n cleared by rd_n", int_n, 1);
    cs_n = 1'b1; st_n = 1'b1;
    step(4);
  endtask

  // Read-mode conversion
  task automatic t_mode2;
    sample_i = 8'h3C;
    cs_n = 1'b0; rd_n = 1'b0;
    step(2);
    chk("R6 oe read", data_oe, 1);
    chk("R4 stale data during read", data_o, 8'hA5);
    chk("R3 busy_n before start", busy_n, 1);
    step(1); chk("R3 busy_n falls", busy_n, 0);
    sample_i = 8'hFF;
    step(7); chk("R4 still stale", data_o, 8'hA5);
    step(1); chk("R3 busy_n ends", busy_n, 1);
    chk("R3 new data", data_o, 8'h3C);
    chk("R5 int_n low", int_n, 0);
    cs_n = 1'b1;
    step(2); chk("R5 int_n held cs", int_n, 0);
    step(1); chk("R5 int_n cleared by cs_n", int_n, 1);
    rd_n = 1'b1;
    step(4);
    chk("R3 no restart", busy_n, 1);
  endtask

  // Second start strobe during a conversion
  task automatic t_overlap;
    sample_i = 8'h11;
    st_n = 1'b0;
    step(3); chk("R9 busy", busy_n, 0);
    st_n = 1'b1;
    step(1);
    sample_i = 8'h22;
    st_n = 1'b0;
    step(6); chk("R9 busy unchanged", busy_n, 0);
    step(1); chk("R9 busy ends on time", busy_n, 1);
    chk("R9 proto_err set", proto_err, 1);
    cs_n = 1'b0; rd_n = 1'b0;
    step(2); chk("R9 result from first start", data_o, 8'h11);
    rd_n = 1'b1; cs_n = 1'b1;
    step(3);
    st_n = 1'b1;
    step(3);
    chk("R9 proto_err sticky", proto_err, 1);
  endtask

  // Output register write rules
  task automatic t_dac;
    data_i = 8'h5A;
    cs_n = 1'b0;
    step(1);
    wr_n = 1'b0;
    step(2);
    wr_n = 1'b1;
    step(2); chk("R7 not yet loaded", dac_q, 8'h00);
    step(1); chk("R7 wr rise loads", dac_q, 8'h5A);
    data_i = 8'h77;
    wr_n = 1'b0;
    step(5); chk("R7 both low holds", dac_q, 8'h5A);
    cs_n = 1'b1;
    step(3); chk("R7 cs rise loads", dac_q, 8'h77);
    wr_n = 1'b1;
    step(1);
    data_i = 8'h99;
    wr_n = 1'b0;
    step(2);
    wr_n = 1'b1;
    step(4); chk("R7 cs high ignores wr", dac_q, 8'h77);
  endtask

  // Bus reset during a conversion
  task automatic t_clr;
    sample_i = 8'h44;
    st_n = 1'b0;
    step(11); chk("R8 first conv int_n", int_n, 0);
    st_n = 1'b1;
    step(2);
    sample_i = 8'hC3;
    st_n = 1'b0;
    step(4);
    clr_n = 1'b0;
    #1;
    chk("R8 int_n forced high", int_n, 1);
    chk("R8 dac_q cleared", dac_q, 0);
    chk("R8 proto_err cleared", proto_err, 0);
    chk("R8 conversion kept", busy_n, 0);
    step(1);
    clr_n = 1'b1;
    sample_i = 8'h00;
    step(5); chk("R8 busy_n still low", busy_n, 0);
    step(1); chk("R8 busy_n ends on time", busy_n, 1);
    chk("R8 int_n after conv", int_n, 0);
    cs_n = 1'b0; rd_n = 1'b0;
    step(2); chk("R8 result intact", data_o, 8'hC3);
    chk("R8 dac_q stays zero", dac_q, 0);
    rd_n = 1'b1; cs_n = 1'b1;
    step(3);
    data_i = 8'h3E;
    cs_n = 1'b0;
    step(1);
    wr_n = 1'b0;
    step(2);
    wr_n = 1'b1;
    step(3); chk("R8 reload after clear", dac_q, 8'h3E);
    cs_n = 1'b1; st_n = 1'b1;
    step(2);
  endtask

  initial begin
    t_reset;
    t_mode1;
    t_mode2;
    t_overlap;
    t_dac;
    t_clr;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule